// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block turns a 10-bit sample code into the switch-control lines of a segmented current-steering converter. The code is split into three fields. The upper six bits drive 63 unit cells through a thermometer decoder. The next two bits drive 3 smaller unit cells through a second thermometer decoder, which works on its own field only. The lowest two bits drive two binary-weighted cells directly. The block is meant to run at up to 100 million samples per second.

All control lines leave the block from one register. Every cell therefore switches on the same clock edge, which keeps skew-induced glitches small. A parameter can add an input register in front of the decoders when timing is tight. A sample-valid input decides whether a new code is loaded into the output register or the previous controls are held. The analog cells and their biasing are outside this block.

Top module: `segdac_switch_decoder`

## Requirements
- R1: The number of asserted lines on `msb_therm_o` equals `code_i[9:4]`, over the range 0 to 63.
- R2: In both thermometer outputs, line k is asserted exactly when its field value is greater than k, so lower-index lines turn on first.
- R3: The number of asserted lines on `mid_therm_o` equals `code_i[3:2]`, over the range 0 to 3, whatever the value of `code_i[9:4]`.
- R4: `lsb_bin_o` equals `code_i[1:0]` with no decoding. Bit 1 has weight 2 and bit 0 has weight 1.
- R5: With `IN_REG`=0, every output shows a code sampled with `valid_i` high on the next rising clock edge, and all outputs change on that same edge.
- R6: With `IN_REG`=1, the latency from input to output is exactly two rising edges.
- R7: A code presented with `valid_i` low leaves all outputs unchanged.
- R8: `rst_n` low at a rising edge clears every output to the all-zero state of code 0. The reset is synchronous and active low.
- R9: For every one of the 1024 codes, 16 × (asserted `msb_therm_o` lines) + 4 × (asserted `mid_therm_o` lines) + `lsb_bin_o` equals the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Load the current code when high |
| code_i | input | 10 | Sample code |
| msb_therm_o | output | 63 | Unary controls for the upper segment, weight 16 each |
| mid_therm_o | output | 3 | Unary controls for the middle segment, weight 4 each |
| lsb_bin_o | output | 2 | Binary-weighted controls, weights 2 and 1 |

## Verification
The bench sweeps all 1024 codes. For each code it checks the line counts, the strict lower-first thermometer shape and the weighted sum.

- An off-by-one comparator would show up at codes where a field is at an extreme: 0, 63 for the upper field, or 3 for the middle field. It would give a wrong count or a gap in the thermometer.
- A middle decoder that took in upper bits would break the sum wherever the upper field is non-zero.
- The bench sends a different code with valid low and checks that the outputs stay put. A design that ignored valid_i would load the new code instead.
- The bench counts the edges of both latency variants, so a missing or extra register stage shows up as early or late data.
- A reset in mid-run must clear a fully lit output.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
    // Number of unary lines a thermometer decoder needs for a w-bit field.
    function automatic int unsigned therm_lines(input int unsigned w);
        return (1 << w) - 1;
    endfunction
endpackage

// File: rtl/segdac_in_stage.sv
module segdac_in_stage #(
    parameter int W  = 10,
    parameter bit EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [W-1:0] code_i,
    output logic         valid_o,
    output logic [W-1:0] code_o
);
    generate
        if (EN) begin : g_reg
            typedef struct packed {
                logic         vld;
                logic [W-1:0] code;
            } stage_t;
            stage_t st_d, st_q;

            always_comb begin
                st_d.vld  = valid_i;
                st_d.code = code_i;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign valid_o = st_q.vld;
            assign code_o  = st_q.code;
        end else begin : g_bypass
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign valid_o    = valid_i;
            assign code_o     = code_i;
        end
    endgenerate
endmodule

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec #(
    parameter int IN_W = 6,
    localparam int LINES = int'(segdac_pkg::therm_lines(IN_W))
) (
    input  logic [IN_W-1:0]  seg_i,
    output logic [LINES-1:0] therm_o
);
    // Line k lights when the field value exceeds k.
    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign therm_o[k] = (int'(seg_i) > k);
    end
endmodule

// File: rtl/segdac_switch_decoder.sv
module segdac_switch_decoder #(
    parameter int MSB_W  = 6,
    parameter int MID_W  = 2,
    parameter int LSB_W  = 2,
    parameter bit IN_REG = 1'b0,
    localparam int CODE_W = MSB_W + MID_W + LSB_W,
    localparam int MSB_L  = int'(segdac_pkg::therm_lines(MSB_W)),
    localparam int MID_L  = int'(segdac_pkg::therm_lines(MID_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [MSB_L-1:0]  msb_therm_o,
    output logic [MID_L-1:0]  mid_therm_o,
    output logic [LSB_W-1:0]  lsb_bin_o
);
    localparam int MID_LO = LSB_W;
    localparam int MSB_LO = LSB_W + MID_W;

    typedef struct packed {
        logic [MSB_L-1:0] msb;
        logic [MID_L-1:0] mid;
        logic [LSB_W-1:0] lsb;
    } sw_t;

    logic              vld_s;
    logic [CODE_W-1:0] code_s;
    logic [MSB_L-1:0]  msb_dec;
    logic [MID_L-1:0]  mid_dec;
    sw_t               sw_d, sw_q;

    segdac_in_stage #(.W(CODE_W), .EN(IN_REG)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .code_i  (code_i),
        .valid_o (vld_s),
        .code_o  (code_s)
    );

    segdac_therm_dec #(.IN_W(MSB_W)) u_msb_dec (
        .seg_i   (code_s[MSB_LO +: MSB_W]),
        .therm_o (msb_dec)
    );

    // Middle decoder sees only its own field.
    segdac_therm_dec #(.IN_W(MID_W)) u_mid_dec (
        .seg_i   (code_s[MID_LO +: MID_W]),
        .therm_o (mid_dec)
    );

    always_comb begin
        sw_d = sw_q;
        if (vld_s) begin
            sw_d.msb = msb_dec;
            sw_d.mid = mid_dec;
            sw_d.lsb = code_s[LSB_W-1:0];
        end
    end

    // One common retiming register for every switch line.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_d;
    end

    assign msb_therm_o = sw_q.msb;
    assign mid_therm_o = sw_q.mid;
    assign lsb_bin_o   = sw_q.lsb;
endmodule

// File: rtl/segdac_chk.sv
module segdac_chk #(
    parameter int MSB_W  = 6,
    parameter int MID_W  = 2,
    parameter int LSB_W  = 2,
    parameter bit IN_REG = 1'b0,
    localparam int CODE_W = MSB_W + MID_W + LSB_W,
    localparam int MSB_L  = (1 << MSB_W) - 1,
    localparam int MID_L  = (1 << MID_W) - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [CODE_W-1:0] code_i,
    input logic [MSB_L-1:0]  msb_therm_o,
    input logic [MID_L-1:0]  mid_therm_o,
    input logic [LSB_W-1:0]  lsb_bin_o
);
    localparam int WM = 1 << (MID_W + LSB_W);
    localparam int WL = 1 << LSB_W;

    int wsum;
    assign wsum = WM * $countones(msb_therm_o) + WL * $countones(mid_therm_o)
                + int'(lsb_bin_o);

    assert_msb_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((msb_therm_o >> 1) & ~msb_therm_o) == '0);
    assert_mid_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mid_therm_o >> 1) & ~mid_therm_o) == '0);
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (msb_therm_o == '0 && mid_therm_o == '0 && lsb_bin_o == '0));

    generate
        if (!IN_REG) begin : g_direct
            assert_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
                valid_i |=> wsum == int'($past(code_i)));
            assert_msb_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
                valid_i |=> $countones(msb_therm_o) == int'($past(code_i[CODE_W-1 -: MSB_W])));
            assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_i |=> $stable(msb_therm_o) && $stable(mid_therm_o) && $stable(lsb_bin_o));
        end else begin : g_staged
            assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) && $past(valid_i) |=> wsum == int'($past(code_i, 2)));
        end
    endgenerate
endmodule

bind segdac_switch_decoder segdac_chk #(
    .MSB_W(MSB_W), .MID_W(MID_W), .LSB_W(LSB_W), .IN_REG(IN_REG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .code_i      (code_i),
    .msb_therm_o (msb_therm_o),
    .mid_therm_o (mid_therm_o),
    .lsb_bin_o   (lsb_bin_o)
);

// File: tb/tb_segdac_switch_decoder.sv
module tb_segdac_switch_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [9:0] code = '0;
    logic [62:0] msb_a, msb_b;
    logic [2:0]  mid_a, mid_b;
    logic [1:0]  lsb_a, lsb_b;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    segdac_switch_decoder dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .code_i(code),
        .msb_therm_o(msb_a), .mid_therm_o(mid_a), .lsb_bin_o(lsb_a));

    segdac_switch_decoder #(.IN_REG(1'b1)) dut_reg (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .code_i(code),
        .msb_therm_o(msb_b), .mid_therm_o(mid_b), .lsb_bin_o(lsb_b));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int wsum(input logic [62:0] m, input logic [2:0] d, input logic [1:0] l);
        return 16 * $countones(m) + 4 * $countones(d) + int'(l);
    endfunction

    function automatic logic [62:0] msb_exp(input int n);
        logic [63:0] t = (64'd1 << n) - 64'd1;
        return t[62:0];
    endfunction

    function automatic logic [2:0] mid_exp(input int n);
        logic [3:0] t = (4'd1 << n) - 4'd1;
        return t[2:0];
    endfunction

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(msb_a == 0 && mid_a == 0 && lsb_a == 0, "R8 reset", longint'(wsum(msb_a, mid_a, lsb_a)), 0);
        check(msb_b == 0 && mid_b == 0 && lsb_b == 0, "R8 reset reg", longint'(wsum(msb_b, mid_b, lsb_b)), 0);
        rst_n = 1'b1;

        // Exhaustive sweep: R1 R2 R3 R4 R5 R9
        for (int c = 0; c < 1024; c++) begin
            @(negedge clk);
            code = 10'(c); valid = 1'b1;
            @(negedge clk);
            check(msb_a == msb_exp(c >> 4), "R1 R2 msb", longint'(msb_a), longint'(msb_exp(c >> 4)));
            check(mid_a == mid_exp((c >> 2) & 3), "R3 R2 mid", longint'(mid_a), longint'(mid_exp((c >> 2) & 3)));
            check(lsb_a == 2'(c), "R4 lsb", longint'(lsb_a), longint'(c & 3));
            check(wsum(msb_a, mid_a, lsb_a) == c, "R9 R5 sum", longint'(wsum(msb_a, mid_a, lsb_a)), longint'(c));
        end

        // R7: valid low holds the previous controls (last code 1023)
        @(negedge clk);
        code = 10'h155; valid = 1'b0;
        repeat (2) @(negedge clk);
        check(wsum(msb_a, mid_a, lsb_a) == 1023, "R7 hold", longint'(wsum(msb_a, mid_a, lsb_a)), 1023);
        check(wsum(msb_b, mid_b, lsb_b) == 1023, "R7 hold reg", longint'(wsum(msb_b, mid_b, lsb_b)), 1023);

        // R5/R6 latency: new code 0x2a6 (678)
        code = 10'h2a6; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        check(wsum(msb_a, mid_a, lsb_a) == 678, "R5 one edge", longint'(wsum(msb_a, mid_a, lsb_a)), 678);
        check(wsum(msb_b, mid_b, lsb_b) == 1023, "R6 not after one edge", longint'(wsum(msb_b, mid_b, lsb_b)), 1023);
        @(negedge clk);
        check(wsum(msb_b, mid_b, lsb_b) == 678, "R6 two edges", longint'(wsum(msb_b, mid_b, lsb_b)), 678);

        // R8: mid-run reset clears a lit output
        code = 10'h3ff; valid = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(msb_a == 0 && mid_a == 0 && lsb_a == 0, "R8 mid-run reset", longint'(wsum(msb_a, mid_a, lsb_a)), 0);
        check(msb_b == 0 && mid_b == 0 && lsb_b == 0, "R8 mid-run reset reg", longint'(wsum(msb_b, mid_b, lsb_b)), 0);
        rst_n = 1'b1; valid = 1'b0;
        @(negedge clk);
        check(wsum(msb_a, mid_a, lsb_a) == 0, "R7 idle after reset", longint'(wsum(msb_a, mid_a, lsb_a)), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end
endmodule